// File: doc/BRIEF.md
# Windowed Chunk Streamer with Per-Slot Retransmission

This block is the worker-side engine of a streamed sum across many workers. It splits a local update vector of `VEC_LEN` elements into chunks of `K` elements and sends them to a remote aggregator. At most `NSLOT` chunks are in flight at once. Each in-flight chunk occupies one slot. The aggregator returns the sum for a slot, and the block writes those values into an external aggregate buffer. That return frees the slot, and the slot then carries the chunk `K*NSLOT` elements further along, with its one-bit version inverted. Sending is therefore clocked by the results themselves.

Packet loss in either direction is repaired only by a per-slot timer. When a slot gets no matching result within `TIMEOUT` cycles, the block sends the identical descriptor again. Results that do not match the slot's outstanding descriptor are dropped, so no chunk is ever written twice. Examples are a stale copy of an older result, a reply that arrives after the slot has timed out, and a corrupted descriptor. The local update memory is read through a combinational port addressed by the offset of the chunk being sent. The last chunk may be partial: elements past the end of the vector are sent as zero and masked on write.

Top module: `chunk_streamer`

## Requirements
- R1: A `start` pulse while idle loads slot i with offset K*i and version 0. Slots whose offset is at or beyond VEC_LEN stay finished. With the send side held ready, the first sends after reset leave in slot order 0, 1, 2, ...
- R2: Each send carries the current slot's offset and version, `tx_wid` equal to `worker_id`, and element j at bits [j*ELEM_W +: ELEM_W] of `tx_data`. Element j equals update element offset+j, or zero when offset+j >= VEC_LEN. `tx_off` is always below VEC_LEN.
- R3: An accepted result produces one aggregate write on the following cycle, with `agg_addr` = result offset and `agg_data` = result data. Bit j of `agg_mask` is set exactly when offset+j < VEC_LEN.
- R4: After an accepted result, the slot's next offset is the old offset plus K*NSLOT, sent with the version inverted. If that offset is at or beyond VEC_LEN, the slot sends nothing more.
- R5: A slot never sends while its previous chunk awaits a result and its timer has not expired.
- R6: A slot that receives no matching result resends the identical descriptor (same slot, version, offset and data). The resend comes no sooner than TIMEOUT+1 cycles after the previous send.
- R7: A result is accepted only if its slot is awaiting a result and its version and offset equal that slot's outstanding ones. Any other result causes no aggregate write, so every chunk is written exactly once.
- R8: A matching result that arrives after the slot's timer expired, but before the resend, is dropped. A matching result after the resend is accepted.
- R9: When several slots are ready to send, a round-robin arbiter picks one per accepted send. The pointer moves past the slot just served.
- R10: `done` rises in the same cycle as the write of the last chunk, and stays high until the next accepted `start`. A `start` pulse while any slot is still sending or waiting has no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin a new vector (ignored while busy) |
| worker_id | input | WID_W | Identifier placed in every send |
| upd_addr | output | OFF_W | Element address of the chunk being sent |
| upd_data | input | K*ELEM_W | Update elements upd_addr .. upd_addr+K-1 |
| tx_valid | output | 1 | A descriptor is offered |
| tx_ready | input | 1 | Descriptor taken this cycle |
| tx_wid | output | WID_W | Worker id |
| tx_ver | output | 1 | Slot version bit |
| tx_slot | output | SLOT_W | Slot index |
| tx_off | output | OFF_W | Element offset of the chunk |
| tx_data | output | K*ELEM_W | Chunk elements, zero past the vector end |
| rx_valid | input | 1 | A result descriptor is present |
| rx_ver | input | 1 | Result version bit |
| rx_slot | input | SLOT_W | Result slot index |
| rx_off | input | OFF_W | Result offset |
| rx_data | input | K*ELEM_W | Summed elements |
| agg_we | output | 1 | Aggregate buffer write strobe |
| agg_addr | output | OFF_W | Element address of the write |
| agg_data | output | K*ELEM_W | Values to write |
| agg_mask | output | K | Per-element write enable |
| done | output | 1 | Every chunk has been written |

## Verification
The hardest case to reach from the ports is a correct, matching result that arrives just after a slot's timer has run out, or just after its resend. Acceptance then depends on the exact cycle. Bringing it about needs a reply delay that straddles the timeout. The stimulus therefore holds some replies back for slightly longer than TIMEOUT, drops other sends outright, and injects stale copies of replies the block has already consumed. It mixes these with random back-pressure on the send side. A bench model tracks each slot's outstanding descriptor and the age of its last send, and predicts for every returned result whether an aggregate write must follow one cycle later.

// File: rtl/stream_pkg.sv
// Shared types for the chunk streamer.
// Assumes: nothing beyond IEEE 1800-2017.
package stream_pkg;
    // Life cycle of one window slot
    typedef enum logic [1:0] {
        SL_IDLE = 2'd0,   // never started since reset
        SL_PEND = 2'd1,   // descriptor ready to send (first send or resend)
        SL_WAIT = 2'd2,   // sent, awaiting its result, timer running
        SL_DONE = 2'd3    // no further chunk for this slot
    } slot_st_e;
endpackage

// File: rtl/stream_slot.sv
// One window slot: holds the outstanding offset and version, runs the
// retransmission timer, matches incoming results and advances by the stride.
// Assumes: start_i is only raised while the slot is not PEND/WAIT, and
// grant_i only while the slot is PEND.
module stream_slot
    import stream_pkg::*;
#(
    parameter int SLOT_IDX = 0,
    parameter int NSLOT    = 4,
    parameter int K        = 2,
    parameter int VEC_LEN  = 21,
    parameter int TIMEOUT  = 250000,
    parameter int OFF_W    = 5,
    parameter int SLOT_W   = 2,
    parameter int TMR_W    = 18
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              grant_i,
    input  logic              rx_valid_i,
    input  logic [SLOT_W-1:0] rx_slot_i,
    input  logic              rx_ver_i,
    input  logic [OFF_W-1:0]  rx_off_i,
    output slot_st_e          st_o,
    output logic              ver_o,
    output logic [OFF_W-1:0]  off_o,
    output logic              hit_o
);
    localparam int INIT_OFF = K * SLOT_IDX;
    localparam int STRIDE   = K * NSLOT;

    logic [TMR_W-1:0] tmr;
    logic [OFF_W-1:0] next_off;

    // Offset this slot carries after its current chunk completes
    assign next_off = off_o + OFF_W'(STRIDE);

    // A result counts only if it names this slot's outstanding descriptor
    assign hit_o = rx_valid_i && (rx_slot_i == SLOT_W'(SLOT_IDX)) &&
                   (st_o == SL_WAIT) && (rx_ver_i == ver_o) && (rx_off_i == off_o);

    // Slot state, descriptor and timer update
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_o  <= SL_IDLE;
            ver_o <= 1'b0;
            off_o <= '0;
            tmr   <= '0;
        end else if (start_i) begin
            off_o <= OFF_W'(INIT_OFF);
            ver_o <= 1'b0;
            tmr   <= '0;
            st_o  <= (INIT_OFF < VEC_LEN) ? SL_PEND : SL_DONE;
        end else if (hit_o) begin
            tmr <= '0;
            if (next_off < OFF_W'(VEC_LEN)) begin
                off_o <= next_off;
                ver_o <= ~ver_o;
                st_o  <= SL_PEND;
            end else begin
                st_o  <= SL_DONE;
            end
        end else if (grant_i) begin
            st_o <= SL_WAIT;
            tmr  <= '0;
        end else if (st_o == SL_WAIT) begin
            if (tmr == TMR_W'(TIMEOUT - 1)) begin
                st_o <= SL_PEND;
                tmr  <= '0;
            end else begin
                tmr <= tmr + 1'b1;
            end
        end
    end
endmodule

// File: rtl/stream_rr.sv
// Round-robin arbiter: grants the first requester at or after the pointer
// and moves the pointer past the grantee when the grant is used.
// Assumes: N >= 2, IDX_W = $clog2(N).
module stream_rr #(
    parameter int N     = 4,
    parameter int IDX_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N-1:0]     req,
    input  logic             adv,
    output logic [N-1:0]     gnt,
    output logic [IDX_W-1:0] gnt_idx
);
    logic [IDX_W-1:0] ptr;

    // Search requests starting from the pointer position
    always_comb begin
        logic found;
        int   c;
        gnt     = '0;
        gnt_idx = '0;
        found   = 1'b0;
        for (int d = 0; d < N; d++) begin
            c = (int'(ptr) + d) % N;
            if (!found && req[c]) begin
                gnt[c]  = 1'b1;
                gnt_idx = IDX_W'(c);
                found   = 1'b1;
            end
        end
    end

    // Pointer moves one past the slot that was served
    always_ff @(posedge clk) begin
        if (!rst_n)
            ptr <= '0;
        else if (adv)
            ptr <= (gnt_idx == IDX_W'(N - 1)) ? '0 : gnt_idx + 1'b1;
    end
endmodule

// File: rtl/chunk_streamer.sv
// Worker-side windowed chunk streamer. Streams a VEC_LEN-element update in
// K-element chunks over NSLOT self-clocked slots, retransmits on per-slot
// timeout and writes accepted sums to an external aggregate buffer.
// Assumes: upd_data is a combinational read of upd_addr; results are always
// accepted; NSLOT >= 2, TIMEOUT >= 2.
module chunk_streamer
    import stream_pkg::*;
#(
    parameter int NSLOT   = 4,
    parameter int K       = 2,
    parameter int ELEM_W  = 16,
    parameter int VEC_LEN = 21,
    parameter int TIMEOUT = 250000,
    parameter int WID_W   = 8,
    localparam int SLOT_W = $clog2(NSLOT),
    localparam int OFF_W  = $clog2(VEC_LEN + K * NSLOT),
    localparam int DW     = K * ELEM_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [WID_W-1:0]  worker_id,
    output logic [OFF_W-1:0]  upd_addr,
    input  logic [DW-1:0]     upd_data,
    output logic              tx_valid,
    input  logic              tx_ready,
    output logic [WID_W-1:0]  tx_wid,
    output logic              tx_ver,
    output logic [SLOT_W-1:0] tx_slot,
    output logic [OFF_W-1:0]  tx_off,
    output logic [DW-1:0]     tx_data,
    input  logic              rx_valid,
    input  logic              rx_ver,
    input  logic [SLOT_W-1:0] rx_slot,
    input  logic [OFF_W-1:0]  rx_off,
    input  logic [DW-1:0]     rx_data,
    output logic              agg_we,
    output logic [OFF_W-1:0]  agg_addr,
    output logic [DW-1:0]     agg_data,
    output logic [K-1:0]      agg_mask,
    output logic              done
);
    localparam int NCHUNK = (VEC_LEN + K - 1) / K;
    localparam int CNT_W  = $clog2(NCHUNK + 1);
    localparam int TMR_W  = $clog2(TIMEOUT + 1);

    slot_st_e          st  [NSLOT];
    logic              ver [NSLOT];
    logic [OFF_W-1:0]  off [NSLOT];
    logic [NSLOT-1:0]  hit, req, act, gnt;
    logic [SLOT_W-1:0] gnt_idx;
    logic              fire, busy, start_go, hit_any;
    logic [K-1:0]      rx_mask;
    logic [CNT_W-1:0]  cnt;

    assign fire     = tx_valid && tx_ready;
    assign busy     = |act;
    assign start_go = start && !busy;
    assign hit_any  = |hit;

    // One controller per window slot
    for (genvar g = 0; g < NSLOT; g++) begin : g_slot
        assign req[g] = (st[g] == SL_PEND);
        assign act[g] = (st[g] == SL_PEND) || (st[g] == SL_WAIT);
        stream_slot #(
            .SLOT_IDX(g), .NSLOT(NSLOT), .K(K), .VEC_LEN(VEC_LEN),
            .TIMEOUT(TIMEOUT), .OFF_W(OFF_W), .SLOT_W(SLOT_W), .TMR_W(TMR_W)
        ) u_slot (
            .clk(clk), .rst_n(rst_n), .start_i(start_go),
            .grant_i(gnt[g] && tx_ready),
            .rx_valid_i(rx_valid), .rx_slot_i(rx_slot), .rx_ver_i(rx_ver),
            .rx_off_i(rx_off),
            .st_o(st[g]), .ver_o(ver[g]), .off_o(off[g]), .hit_o(hit[g])
        );
    end

    stream_rr #(.N(NSLOT), .IDX_W(SLOT_W)) u_rr (
        .clk(clk), .rst_n(rst_n), .req(req), .adv(fire),
        .gnt(gnt), .gnt_idx(gnt_idx)
    );

    // Descriptor of the granted slot
    assign tx_valid = |req;
    assign tx_slot  = gnt_idx;
    assign tx_off   = off[gnt_idx];
    assign tx_ver   = ver[gnt_idx];
    assign tx_wid   = worker_id;
    assign upd_addr = tx_off;

    // Per-element zero padding on send and write mask on receive
    for (genvar j = 0; j < K; j++) begin : g_elem
        assign tx_data[j*ELEM_W +: ELEM_W] =
            (({1'b0, tx_off} + (OFF_W+1)'(j)) < (OFF_W+1)'(VEC_LEN)) ?
            upd_data[j*ELEM_W +: ELEM_W] : '0;
        assign rx_mask[j] = ({1'b0, rx_off} + (OFF_W+1)'(j)) < (OFF_W+1)'(VEC_LEN);
    end

    // Registered aggregate write for an accepted result
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            agg_we   <= 1'b0;
            agg_addr <= '0;
            agg_data <= '0;
            agg_mask <= '0;
        end else begin
            agg_we <= hit_any;
            if (hit_any) begin
                agg_addr <= rx_off;
                agg_data <= rx_data;
                agg_mask <= rx_mask;
            end
        end
    end

    // Count completed chunks and raise done with the last write
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt  <= '0;
            done <= 1'b0;
        end else if (start_go) begin
            cnt  <= '0;
            done <= 1'b0;
        end else if (hit_any) begin
            cnt <= cnt + 1'b1;
            if (cnt == CNT_W'(NCHUNK - 1))
                done <= 1'b1;
        end
    end
endmodule

// File: rtl/chunk_streamer_chk.sv
// Property checker for chunk_streamer, attached by bind.
// Assumes: connected to the top's ports and its internal grant vector.
module chunk_streamer_chk #(
    parameter int NSLOT   = 4,
    parameter int K       = 2,
    parameter int VEC_LEN = 21,
    parameter int OFF_W   = 5,
    parameter int SLOT_W  = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic              tx_valid,
    input logic [OFF_W-1:0]  tx_off,
    input logic              rx_valid,
    input logic              agg_we,
    input logic [K-1:0]      agg_mask,
    input logic              done,
    input logic [NSLOT-1:0]  gnt
);
    p_grant_onehot_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(gnt));

    p_grant_when_valid_r9: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid |-> $countones(gnt) == 1);

    p_tx_in_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid |-> (int'(tx_off) < VEC_LEN));

    p_write_from_result_r3: assert property (@(posedge clk) disable iff (!rst_n)
        agg_we |-> $past(rx_valid));

    p_write_mask_lead_r3: assert property (@(posedge clk) disable iff (!rst_n)
        agg_we |-> agg_mask[0]);

    p_done_holds_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !start) |=> done);

    p_no_write_after_done_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (done && $past(done)) |-> !agg_we);
endmodule

bind chunk_streamer chunk_streamer_chk #(
    .NSLOT(NSLOT), .K(K), .VEC_LEN(VEC_LEN), .OFF_W(OFF_W), .SLOT_W(SLOT_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .start(start), .tx_valid(tx_valid),
    .tx_off(tx_off), .rx_valid(rx_valid), .agg_we(agg_we),
    .agg_mask(agg_mask), .done(done), .gnt(gnt)
);

// File: tb/chunk_streamer_bench.sv
// Self-checking bench: seeded random loss, delay, duplicates and back-pressure,
// plus directed start-order and busy-start cases, against a slot model.
module chunk_streamer_bench;
    localparam int NS  = 4;
    localparam int K   = 2;
    localparam int EW  = 16;
    localparam int VEC = 21;
    localparam int T   = 40;
    localparam int WW  = 8;
    localparam int SW  = 2;
    localparam int OW  = $clog2(VEC + K * NS);
    localparam int DW  = K * EW;
    localparam int NCH = (VEC + K - 1) / K;
    localparam int QN  = 64;

    logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
    logic [WW-1:0] worker_id = 8'h5A;
    logic [OW-1:0] upd_addr;
    logic [DW-1:0] upd_data;
    logic tx_valid, tx_ready = 1'b0, tx_ver;
    logic [WW-1:0] tx_wid;
    logic [SW-1:0] tx_slot;
    logic [OW-1:0] tx_off;
    logic [DW-1:0] tx_data;
    logic rx_valid = 1'b0, rx_ver = 1'b0;
    logic [SW-1:0] rx_slot = '0;
    logic [OW-1:0] rx_off = '0;
    logic [DW-1:0] rx_data = '0;
    logic agg_we, done;
    logic [OW-1:0] agg_addr;
    logic [DW-1:0] agg_data;
    logic [K-1:0] agg_mask;

    always #2 clk = ~clk;

    chunk_streamer #(.NSLOT(NS), .K(K), .ELEM_W(EW), .VEC_LEN(VEC),
                     .TIMEOUT(T), .WID_W(WW)) u_chunk_streamer (.*);

    logic [EW-1:0] mem [VEC];
    logic [EW-1:0] aggbuf [VEC];

    // Combinational update memory, garbage past the vector end
    always_comb begin
        for (int j = 0; j < K; j++) begin
            if (int'(upd_addr) + j < VEC) upd_data[j*EW +: EW] = mem[int'(upd_addr) + j];
            else                          upd_data[j*EW +: EW] = 16'hDEAD;
        end
    end

    int n_checks = 0, n_fail = 0, cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    // Slot model
    bit s_wait [NS]; bit s_sent [NS]; bit s_done [NS]; bit s_ver [NS];
    int s_off [NS]; int s_fire [NS];
    int wr_cnt [NCH];
    int accepted = 0, nfire = 0;
    // Expected aggregate write for the coming negedge
    bit exp_we = 0; int exp_off = 0; logic [DW-1:0] exp_data = '0;
    // Response queue
    bit q_use [QN]; int q_cyc [QN]; int q_slot [QN]; int q_off [QN];
    bit q_ver [QN]; logic [DW-1:0] q_data [QN];
    // Knobs
    bit running = 0, order_chk = 0, rand_ready = 0, start_req = 0, poke_req = 0;
    int hold0 = 0, drop_pct = 0, late_pct = 0, dup_pct = 0, bogus_pct = 0;

    task automatic check(input bit ok, input string rq, input string what,
                         input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h", rq, what, act, exp);
        end
    endtask

    function automatic logic [DW-1:0] chunk_exp(input int o);
        logic [DW-1:0] d;
        for (int j = 0; j < K; j++) d[j*EW +: EW] = (o + j < VEC) ? mem[o + j] : '0;
        return d;
    endfunction

    function automatic logic [K-1:0] mask_exp(input int o);
        logic [K-1:0] m;
        for (int j = 0; j < K; j++) m[j] = (o + j < VEC);
        return m;
    endfunction

    function automatic logic [DW-1:0] summed(input logic [DW-1:0] d);
        logic [DW-1:0] r;
        for (int j = 0; j < K; j++) r[j*EW +: EW] = d[j*EW +: EW] + 16'h1111;
        return r;
    endfunction

    function automatic bit model_busy();
        for (int i = 0; i < NS; i++) if (!s_done[i]) return 1;
        return 0;
    endfunction

    task automatic push(input int at, input int sl, input bit v, input int o,
                        input logic [DW-1:0] d);
        for (int e = 0; e < QN; e++) begin
            if (!q_use[e]) begin
                q_use[e] = 1; q_cyc[e] = at; q_slot[e] = sl; q_ver[e] = v;
                q_off[e] = o; q_data[e] = d;
                return;
            end
        end
    endtask

    int sl, age, pick;
    bit acc, match;

    always @(negedge clk) begin
        if (running) begin
            // Aggregate write predicted last cycle (R3, R7)
            if (exp_we) begin
                check(agg_we == 1'b1, "R3", "agg_we", agg_we, 1);
                check(int'(agg_addr) == exp_off, "R3", "agg_addr", agg_addr, exp_off);
                check(agg_data == exp_data, "R3", "agg_data", agg_data, exp_data);
                check(agg_mask == mask_exp(exp_off), "R3", "agg_mask", agg_mask, mask_exp(exp_off));
                for (int j = 0; j < K; j++)
                    if (exp_off + j < VEC) aggbuf[exp_off + j] = agg_data[j*EW +: EW];
                wr_cnt[exp_off / K]++;
                check(wr_cnt[exp_off / K] == 1, "R7", "chunk write count", wr_cnt[exp_off / K], 1);
            end else begin
                check(agg_we == 1'b0, "R7", "unexpected agg_we", agg_we, 0);
            end
            check(done == (accepted == NCH), "R10", "done", done, accepted == NCH);
            exp_we = 0;
            rx_valid = 1'b0;

            if (start) begin
                start = 1'b0;
                tx_ready = 1'b0;
            end else if (start_req) begin
                // Accepted start: reload model (R1)
                start_req = 0; start = 1'b1; tx_ready = 1'b0;
                for (int i = 0; i < NS; i++) begin
                    s_off[i] = K * i; s_ver[i] = 0; s_wait[i] = 0; s_sent[i] = 0;
                    s_done[i] = (K * i >= VEC); s_fire[i] = 0;
                end
                for (int c = 0; c < NCH; c++) wr_cnt[c] = 0;
                for (int e = 0; e < QN; e++) q_use[e] = 0;
                accepted = 0; nfire = 0;
            end else begin
                if (poke_req && model_busy()) begin
                    poke_req = 0; start = 1'b1;   // must be ignored (R10)
                end
                // Deliver at most one result
                pick = -1;
                for (int e = 0; e < QN; e++)
                    if (pick < 0 && q_use[e] && q_cyc[e] <= cyc + 1) pick = e;
                if (pick >= 0) begin
                    q_use[pick] = 0;
                    rx_valid = 1'b1; rx_slot = SW'(q_slot[pick]); rx_ver = q_ver[pick];
                    rx_off = OW'(q_off[pick]); rx_data = q_data[pick];
                end else if (($urandom % 100) < bogus_pct) begin
                    rx_valid = 1'b1; rx_slot = SW'($urandom % NS); rx_ver = 1'($urandom);
                    rx_off = OW'(2 * ($urandom % (VEC / 2)) + 1); rx_data = DW'($urandom);
                end
                if (rx_valid) begin
                    sl = int'(rx_slot);
                    age = cyc + 1 - s_fire[sl];
                    match = s_wait[sl] && rx_ver == s_ver[sl] && int'(rx_off) == s_off[sl];
                    acc = match && age >= 1 && age <= T;   // R7, R8
                    if (acc) begin
                        exp_we = 1; exp_off = s_off[sl]; exp_data = rx_data;
                        s_wait[sl] = 0; s_sent[sl] = 0; accepted++;
                        s_off[sl] += K * NS; s_ver[sl] ^= 1'b1;   // R4
                        if (s_off[sl] >= VEC) s_done[sl] = 1;
                    end else if (match) begin
                        check(1'b1, "R8", "late result dropped", 0, 0);
                    end
                end
                // Send side
                if (hold0 > 0) begin
                    hold0--; tx_ready = 1'b0;
                end else begin
                    tx_ready = rand_ready ? (($urandom % 4) != 0) : 1'b1;
                end
                if (tx_valid && tx_ready) begin
                    sl = int'(tx_slot);
                    age = cyc + 1 - s_fire[sl];
                    if (order_chk && nfire < NS)
                        check(sl == nfire, "R9", "initial grant order (R1)", sl, nfire);
                    nfire++;
                    check(!(s_wait[sl] && age <= T), "R5", "send while outstanding", age, T + 1);
                    check(!s_done[sl], "R4", "send from finished slot", sl, 0);
                    check(int'(tx_off) == s_off[sl], "R4", "tx_off", tx_off, s_off[sl]);
                    check(tx_ver == s_ver[sl], "R4", "tx_ver", tx_ver, s_ver[sl]);
                    check(tx_data == chunk_exp(s_off[sl]), "R2", "tx_data",
                          tx_data, chunk_exp(s_off[sl]));
                    check(tx_wid == worker_id, "R2", "tx_wid", tx_wid, worker_id);
                    if (s_sent[sl])
                        check(age >= T + 1, "R6", "resend too early", age, T + 1);
                    s_fire[sl] = cyc + 1; s_wait[sl] = 1; s_sent[sl] = 1;
                    if (($urandom % 100) >= drop_pct) begin
                        if (($urandom % 100) < late_pct)
                            push(cyc + 1 + T + 1 + int'($urandom % 6), sl, tx_ver,
                                 int'(tx_off), summed(tx_data));
                        else
                            push(cyc + 2 + int'($urandom % (T / 2)), sl, tx_ver,
                                 int'(tx_off), summed(tx_data));
                        if (($urandom % 100) < dup_pct)
                            push(cyc + 2 * T + int'($urandom % T), sl, tx_ver,
                                 int'(tx_off), summed(tx_data));
                    end
                end
            end
        end
    end

    task automatic run_until_done(input string tag);
        int n;
        n = 0;
        while (!(accepted == NCH && !start_req) && n < 30000) begin
            @(negedge clk); n++;
        end
        if (n >= 30000) check(1'b0, "R10", {"watchdog ", tag}, accepted, NCH);
        repeat (4) @(negedge clk);
        for (int a = 0; a < VEC; a++)
            check(aggbuf[a] == mem[a] + 16'h1111, "R3", "final buffer",
                  aggbuf[a], mem[a] + 16'h1111);
        for (int c = 0; c < NCH; c++)
            check(wr_cnt[c] == 1, "R7", "chunk written once", wr_cnt[c], 1);
    endtask

    initial begin
        void'($urandom(32'd20240611));
        for (int a = 0; a < VEC; a++) begin mem[a] = EW'($urandom); aggbuf[a] = '0; end
        for (int i = 0; i < NS; i++) begin s_done[i] = 1; s_wait[i] = 0; s_fire[i] = 0; end
        repeat (4) @(negedge clk);
        // Reset state (R1, R10)
        check(tx_valid == 1'b0, "R1", "tx_valid in reset", tx_valid, 0);
        check(done == 1'b0, "R10", "done in reset", done, 0);
        check(agg_we == 1'b0, "R3", "agg_we in reset", agg_we, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(tx_valid == 1'b0, "R1", "idle before start", tx_valid, 0);
        running = 1;

        // Directed: lossless, held-off ready then full ready (R1, R9)
        order_chk = 1; hold0 = 3; start_req = 1;
        run_until_done("lossless");
        order_chk = 0;

        // Random loss, late replies, duplicates, bogus results, busy start
        rand_ready = 1; drop_pct = 20; late_pct = 12; dup_pct = 20; bogus_pct = 10;
        for (int a = 0; a < VEC; a++) aggbuf[a] = '0;
        start_req = 1;
        repeat (30) @(negedge clk);
        poke_req = 1;
        run_until_done("lossy");

        // Restart after completion: versions begin at 0 again
        for (int a = 0; a < VEC; a++) begin mem[a] = EW'($urandom); aggbuf[a] = '0; end
        late_pct = 25;
        start_req = 1;
        run_until_done("restart");

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    // Global watchdog
    initial begin
        repeat (180000) @(posedge clk);
        n_checks++; n_fail++;
        $display("FAIL R10 watchdog expired actual=%0d expected=%0d", accepted, NCH);
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule